// File: doc/BRIEF.md
# Dual-Counter Capture/Compare Timer

This block is a 16-bit timer built on two up-counters that any of several channels can share. Each counter either runs through the whole 16-bit range and wraps, or restarts when it reaches its own period register, which shortens its cycle. A counter raises either an overflow pulse or a period pulse on each restart. Which one it raises depends on whether its period holds the all-ones value.

Each channel selects one of the two counters at run time. It then works in one of three modes. In capture mode it latches the counter on a chosen edge of its input pin. In compare mode it toggles its output on a match. In PWM mode it drives a pulse-width waveform whose compare value is double-buffered up to the counter's restart. Software configures the block through a single-cycle synchronous write port. Counter values and captured values are visible on output ports.

Top module: `dual_ctr_timer`

## Requirements
- R1: Register map. Address 0 is control: bit0 runs counter 0, bit1 runs counter 1, bit2 puts counter 0 in restart-on-period mode, bit3 does the same for counter 1. Address 1 is the period of counter 0 and address 2 the period of counter 1; both reset to 0xFFFF. Address 8+i configures channel i: bits[1:0] mode (0 capture, 1 compare, 2 PWM), bit2 counter select, bit3 output enable, bits[5:4] edge (0 rising, 1 falling, 2 or 3 both). Address 16+i is the compare value of channel i.
- R2: In restart-on-period mode with a period P other than 0xFFFF, the counter counts 0..P and then returns to 0. When it returns to 0 it pulses the period interrupt for one cycle, in the cycle where the count reads 0. It raises no overflow pulse.
- R3: A counter in wrap mode ignores its period and wraps from 0xFFFF to 0 with a one-cycle overflow pulse. In restart-on-period mode with period 0xFFFF, the overflow pulse fires and the period pulse does not.
- R4: A counter whose run bit is 0 reads 0 one cycle later and stays there.
- R5: A channel's counter-select bit 0 binds it to counter 0 and bit 1 binds it to counter 1, for capture as well as compare.
- R6: In capture mode, the selected input edge is detected after a two-flop synchronizer. The captured count is the one present two clock edges after the input change is first sampled. The capture register and a one-cycle channel interrupt update at the next edge. Without an edge, the capture register holds its value.
- R7: The edge field selects the capture polarity. A channel set to falling-only ignores rising edges.
- R8: If a capture and a counter restart fall in the same cycle, the latched value is the pre-restart count, equal to the period.
- R9: In compare mode, a newly written compare value applies at once. When the running counter equals it, the channel interrupt pulses and the output toggles, both visible one cycle later.
- R10: In PWM mode, while the counter shows value v, the output is high exactly when v is less than the active compare value C. C = 0 keeps the output low. A C above the period keeps it high.
- R11: In PWM mode, a compare write takes effect only from the cycle the counter restarts, or at once if the counter is stopped.
- R12: The output of a channel with output enable 0, or in capture mode, stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (5) | Register address |
| wr_data | input | CW (16) | Register write data |
| tin_i | input | NCH (4) | Channel capture inputs |
| cnt0_o | output | CW | Counter 0 value |
| cnt1_o | output | CW | Counter 1 value |
| cap_o | output | NCH*CW | Captured values, channel i at bits [i*CW +: CW] |
| ovf_irq_o | output | 2 | Overflow pulse per counter |
| prd_irq_o | output | 2 | Period pulse per counter |
| ch_irq_o | output | NCH | Capture/match pulse per channel |
| tout_o | output | NCH | Channel timer outputs |

## Verification
The case of interest is a capture edge that lands in the same cycle as a counter restart. The bench runs a counter with a short period and toggles a channel input again and again, with a growing idle gap between toggles so that detection walks through every phase of the count. For each capture, the expected value is the counter port sampled in the detection cycle. The bench requires that at least one capture falls on the period value. In that case the register must hold the period and not zero. A second overlap is also covered: a PWM compare write arriving mid-period, checked against the restart that releases it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        CH_CAPTURE = 2'd0,
        CH_COMPARE = 2'd1,
        CH_PWM     = 2'd2,
        CH_RSVD    = 2'd3
    } ch_mode_e;

    typedef enum logic [1:0] {
        EDG_RISE  = 2'd0,
        EDG_FALL  = 2'd1,
        EDG_BOTH  = 2'd2,
        EDG_BOTHX = 2'd3
    } edge_sel_e;

    // channel configuration word, bits [5:0]
    typedef struct packed {
        edge_sel_e edge_sel;  // [5:4]
        logic      oe;        // [3]
        logic      sel;       // [2]
        ch_mode_e  mode;      // [1:0]
    } ch_cfg_t;

    // control word, bits [3:0]
    typedef struct packed {
        logic mc1;
        logic mc0;
        logic run1;
        logic run0;
    } tmr_ctrl_t;

    localparam int NCTR = 2;

    function automatic logic edge_hit(edge_sel_e sel, logic cur, logic prv);
        case (sel)
            EDG_RISE: return cur & ~prv;
            EDG_FALL: return ~cur & prv;
            default:  return cur ^ prv;
        endcase
    endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          clr_mode,
    input  logic [CW-1:0] period,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_nxt,
    output logic          wrap,
    output logic          ovf_irq,
    output logic          prd_irq
);
    localparam logic [CW-1:0] ALL1 = {CW{1'b1}};
    localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

    logic full_prd;
    logic ovf_evt;
    logic prd_evt;

    always_comb begin
        full_prd = (period == ALL1);
        wrap     = run && (clr_mode ? (cnt == period) : (cnt == ALL1));
        ovf_evt  = wrap && (!clr_mode || full_prd);
        prd_evt  = wrap && clr_mode && !full_prd;
        if (!run || wrap) cnt_nxt = '0;
        else              cnt_nxt = cnt + ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            ovf_irq <= 1'b0;
            prd_irq <= 1'b0;
        end else begin
            cnt     <= cnt_nxt;
            ovf_irq <= ovf_evt;
            prd_irq <= prd_evt;
        end
    end

    p_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (run && clr_mode && cnt == period) |=> (cnt == '0));

    p_stop_r4: assert property (@(posedge clk) disable iff (rst)
        (!run) |=> (cnt == '0));

    p_irq_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(ovf_irq && prd_irq));

    p_ovf_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_irq |=> !ovf_irq);

endmodule

// File: rtl/tmr_edge_det.sv
module tmr_edge_det
    import tmr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      din,
    input  edge_sel_e sel,
    output logic      hit
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], din};
    end

    assign hit = edge_hit(sel, sh[STAGES-1], sh[STAGES]);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  ch_cfg_t                  cfg,
    input  logic                     cmp_we,
    input  logic [CW-1:0]            cmp_wdata,
    input  logic                     tin,
    input  logic [NCTR-1:0][CW-1:0]  cnt,
    input  logic [NCTR-1:0][CW-1:0]  nxt,
    input  logic [NCTR-1:0]          wrap,
    input  logic [NCTR-1:0]          run,
    output logic [CW-1:0]            cap,
    output logic                     irq,
    output logic                     tout
);
    logic [CW-1:0] cnt_s, nxt_s;
    logic          wrap_s, run_s, load;
    logic [CW-1:0] act_q, act_d, shd_q;
    logic          lvl_q, lvl_d;
    logic          hit, cap_evt, match;
    logic          tout_d, irq_d;

    tmr_edge_det #(.STAGES(2)) u_edge (
        .clk (clk),
        .rst (rst),
        .din (tin),
        .sel (cfg.edge_sel),
        .hit (hit)
    );

    always_comb begin
        cnt_s  = cnt[cfg.sel];
        nxt_s  = nxt[cfg.sel];
        wrap_s = wrap[cfg.sel];
        run_s  = run[cfg.sel];
        load   = wrap_s || !run_s;

        act_d = act_q;
        if (cfg.mode == CH_PWM) begin
            if (load) act_d = cmp_we ? cmp_wdata : shd_q;
        end else if (cmp_we) begin
            act_d = cmp_wdata;
        end

        match   = run_s && (cnt_s == act_q);
        cap_evt = (cfg.mode == CH_CAPTURE) && hit;
        lvl_d   = lvl_q ^ ((cfg.mode == CH_COMPARE) && match);

        case (cfg.mode)
            CH_CAPTURE: begin tout_d = 1'b0;                              irq_d = cap_evt; end
            CH_COMPARE: begin tout_d = cfg.oe && lvl_d;                   irq_d = match;   end
            CH_PWM:     begin tout_d = cfg.oe && run_s && (nxt_s < act_d); irq_d = match;   end
            default:    begin tout_d = 1'b0;                              irq_d = 1'b0;    end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            shd_q <= '0;
            cap   <= '0;
            lvl_q <= 1'b0;
            tout  <= 1'b0;
            irq   <= 1'b0;
        end else begin
            act_q <= act_d;
            if (cmp_we) shd_q <= cmp_wdata;
            if (cap_evt) cap <= cnt_s;
            lvl_q <= lvl_d;
            tout  <= tout_d;
            irq   <= irq_d;
        end
    end

    p_cap_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !cap_evt |=> $stable(cap));

    p_tout_off_r12: assert property (@(posedge clk) disable iff (rst)
        (!cfg.oe || cfg.mode == CH_CAPTURE) |=> !tout);

    p_pwm_defer_r11: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == CH_PWM && !load) |=> $stable(act_q));

endmodule

// File: rtl/dual_ctr_timer.sv
module dual_ctr_timer
    import tmr_pkg::*;
#(
    parameter int CW  = 16,
    parameter int NCH = 4,
    parameter int AW  = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [CW-1:0]       wr_data,
    input  logic [NCH-1:0]      tin_i,
    output logic [CW-1:0]       cnt0_o,
    output logic [CW-1:0]       cnt1_o,
    output logic [NCH*CW-1:0]   cap_o,
    output logic [NCTR-1:0]     ovf_irq_o,
    output logic [NCTR-1:0]     prd_irq_o,
    output logic [NCH-1:0]      ch_irq_o,
    output logic [NCH-1:0]      tout_o
);
    localparam int CTRL_ADDR = 0;
    localparam int PRD_BASE  = 1;
    localparam int CFG_BASE  = 8;
    localparam int CMP_BASE  = 16;
    localparam int CFG_W     = $bits(ch_cfg_t);
    localparam int CTRL_W    = $bits(tmr_ctrl_t);

    tmr_ctrl_t                 ctrl_q;
    logic [NCTR-1:0][CW-1:0]   prd_q;
    ch_cfg_t                   cfg_q [NCH];
    logic [NCH-1:0]            cmp_we;

    logic [NCTR-1:0][CW-1:0]   cnt_w, nxt_w;
    logic [NCTR-1:0]           wrap_w, run_w, mc_w;

    assign run_w = {ctrl_q.run1, ctrl_q.run0};
    assign mc_w  = {ctrl_q.mc1, ctrl_q.mc0};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            for (int k = 0; k < NCTR; k++) prd_q[k] <= '1;
            for (int i = 0; i < NCH; i++) cfg_q[i] <= '0;
        end else if (wr_en) begin
            if (wr_addr == AW'(CTRL_ADDR)) ctrl_q <= tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
            for (int k = 0; k < NCTR; k++)
                if (wr_addr == AW'(PRD_BASE + k)) prd_q[k] <= wr_data;
            for (int i = 0; i < NCH; i++)
                if (wr_addr == AW'(CFG_BASE + i)) cfg_q[i] <= ch_cfg_t'(wr_data[CFG_W-1:0]);
        end
    end

    always_comb begin
        for (int i = 0; i < NCH; i++)
            cmp_we[i] = wr_en && (wr_addr == AW'(CMP_BASE + i));
    end

    for (genvar k = 0; k < NCTR; k++) begin : g_ctr
        tmr_counter #(.CW(CW)) u_ctr (
            .clk      (clk),
            .rst      (rst),
            .run      (run_w[k]),
            .clr_mode (mc_w[k]),
            .period   (prd_q[k]),
            .cnt      (cnt_w[k]),
            .cnt_nxt  (nxt_w[k]),
            .wrap     (wrap_w[k]),
            .ovf_irq  (ovf_irq_o[k]),
            .prd_irq  (prd_irq_o[k])
        );
    end

    assign cnt0_o = cnt_w[0];
    assign cnt1_o = cnt_w[1];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tmr_channel #(.CW(CW)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .cfg       (cfg_q[i]),
            .cmp_we    (cmp_we[i]),
            .cmp_wdata (wr_data),
            .tin       (tin_i[i]),
            .cnt       (cnt_w),
            .nxt       (nxt_w),
            .wrap      (wrap_w),
            .run       (run_w),
            .cap       (cap_o[i*CW +: CW]),
            .irq       (ch_irq_o[i]),
            .tout      (tout_o[i])
        );
    end

    p_ctrl_write_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == AW'(CTRL_ADDR) && !wr_data[0]) |=> ##1 (cnt0_o == '0));

endmodule

// File: tb/tb_dual_ctr_timer.sv
module tb_dual_ctr_timer;
    localparam int CW  = 16;
    localparam int NCH = 4;
    localparam int AW  = 5;

    // {period, compare, expected high cycles per period}
    localparam logic [47:0] PWM_TAB [6] = '{
        48'h0009_0003_0003,
        48'h0009_0000_0000,
        48'h0009_000A_000A,
        48'h0009_000C_000A,
        48'h0004_0002_0002,
        48'h000F_0008_0008
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic [CW-1:0]     wr_data = '0;
    logic [NCH-1:0]    tin_i = '0;
    logic [CW-1:0]     cnt0_o, cnt1_o;
    logic [NCH*CW-1:0] cap_o;
    logic [1:0]        ovf_irq_o, prd_irq_o;
    logic [NCH-1:0]    ch_irq_o, tout_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dual_ctr_timer #(.CW(CW), .NCH(NCH), .AW(AW)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tin_i(tin_i), .cnt0_o(cnt0_o), .cnt1_o(cnt1_o), .cap_o(cap_o),
        .ovf_irq_o(ovf_irq_o), .prd_irq_o(prd_irq_o), .ch_irq_o(ch_irq_o), .tout_o(tout_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        wr_en   = 1'b1;
        wr_addr = AW'(a);
        wr_data = CW'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic logic [CW-1:0] capv(input int ch);
        return cap_o[ch*CW +: CW];
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int v, prev, cur, hi, hits, cnt_irq, exp;
        int o0, o1, p0, p1;
        logic exp_lvl;

        repeat (3) step();
        rst = 1'b0;
        step();

        // reset state
        chk(cnt0_o == 0 && cnt1_o == 0, "R4 reset counters", cnt0_o, 0);
        chk(tout_o == 0, "R12 reset outputs", tout_o, 0);
        chk(ovf_irq_o == 0 && prd_irq_o == 0 && ch_irq_o == 0, "R2 reset irqs", ch_irq_o, 0);
        chk(cap_o == 0, "R6 reset capture", 0, 0);

        // PWM duty table on channel 0, counter 0
        foreach (PWM_TAB[r]) begin
            int p, c, e;
            p = int'(PWM_TAB[r][47:32]);
            c = int'(PWM_TAB[r][31:16]);
            e = int'(PWM_TAB[r][15:0]);
            wr(0, 0);
            wr(1, p);
            wr(8, 16'h000A);
            wr(16, c);
            wr(0, 16'h0005);
            repeat (2 * (p + 1)) step();
            hi = 0;
            for (int j = 0; j < p + 1; j++) begin
                if (tout_o[0]) hi++;
                step();
            end
            chk(hi == e, "R10 pwm high cycles", hi, e);
        end

        // deferred PWM reload
        wr(0, 0);
        wr(1, 9);
        wr(16, 3);
        wr(0, 16'h0005);
        for (int j = 0; j < 20 && cnt0_o != 1; j++) step();
        wr(16, 7);
        cur = 3;
        for (int j = 0; j < 25; j++) begin
            v = int'(cnt0_o);
            if (v == 0) cur = 7;
            chk(tout_o[0] == (v < cur), "R11 pwm reload timing", tout_o[0], (v < cur));
            step();
        end

        // output disabled; period interrupt on counter 0
        wr(8, 16'h0002);
        prev = int'(cnt0_o);
        step();
        for (int j = 0; j < 25; j++) begin
            v = int'(cnt0_o);
            chk(tout_o[0] == 1'b0, "R12 disabled output", tout_o[0], 0);
            chk(prd_irq_o[0] == (v == 0 && prev == 9), "R2 period pulse", prd_irq_o[0], (v == 0 && prev == 9));
            chk(ovf_irq_o[0] == 1'b0, "R2 no overflow", ovf_irq_o[0], 0);
            chk(v <= 9, "R2 count range", v, 9);
            prev = v;
            step();
        end

        // capture on channel 1 (counter 0, both edges), sweeping phases
        wr(9, 16'h0028);
        hits = 0;
        for (int it = 0; it < 12; it++) begin
            tin_i[1] = ~tin_i[1];
            step();
            step();
            exp = int'(cnt0_o);
            step();
            chk(int'(capv(1)) == exp, "R6 captured count", capv(1), exp);
            chk(ch_irq_o[1] == 1'b1, "R6 capture pulse", ch_irq_o[1], 1);
            chk(tout_o[1] == 1'b0, "R12 capture output low", tout_o[1], 0);
            if (exp == 9) begin
                hits++;
                chk(capv(1) == 16'd9, "R8 pre-restart capture", capv(1), 9);
            end
            step();
            chk(ch_irq_o[1] == 1'b0, "R6 pulse width", ch_irq_o[1], 0);
            repeat (it % 10) step();
        end
        chk(hits > 0, "R8 coincidence reached", hits, 1);

        // stop counter 0, run counter 1 free
        wr(0, 16'h0002);
        step();
        chk(cnt0_o == 0, "R4 stopped counter", cnt0_o, 0);
        wr(10, 16'h0014);
        tin_i[2] = 1'b1;
        cnt_irq = 0;
        for (int j = 0; j < 6; j++) begin
            if (ch_irq_o[2]) cnt_irq++;
            step();
        end
        chk(cnt_irq == 0, "R7 rising ignored", cnt_irq, 0);
        chk(capv(2) == 0, "R7 capture untouched", capv(2), 0);
        tin_i[2] = 1'b0;
        step();
        step();
        exp = int'(cnt1_o);
        step();
        chk(int'(capv(2)) == exp && exp != 0, "R5 counter 1 selected", capv(2), exp);
        chk(ch_irq_o[2] == 1'b1, "R7 falling captured", ch_irq_o[2], 1);

        // compare mode on channel 3, counter 1, period 19
        wr(0, 0);
        wr(2, 19);
        wr(11, 16'h000D);
        wr(19, 5);
        wr(0, 16'h000A);
        exp_lvl = 1'b0;
        prev = int'(cnt1_o);
        step();
        for (int j = 0; j < 45; j++) begin
            v = int'(cnt1_o);
            if (prev == 5) exp_lvl = ~exp_lvl;
            chk(ch_irq_o[3] == (prev == 5), "R9 match pulse", ch_irq_o[3], (prev == 5));
            chk(tout_o[3] == exp_lvl, "R9 output toggle", tout_o[3], exp_lvl);
            prev = v;
            step();
        end
        for (int j = 0; j < 30 && cnt1_o != 2; j++) step();
        wr(19, 12);
        hits = 0;
        for (int j = 0; j < 20; j++) begin
            v = int'(cnt1_o);
            if (v == 13) begin
                chk(ch_irq_o[3] == 1'b1, "R9 new value immediate", ch_irq_o[3], 1);
                hits++;
                break;
            end
            chk(ch_irq_o[3] == 1'b0, "R9 no early match", ch_irq_o[3], 0);
            step();
        end
        chk(hits == 1, "R9 match reached", hits, 1);

        // full-range: counter 0 wraps, counter 1 restart mode with all-ones period
        wr(0, 0);
        wr(2, 16'hFFFF);
        wr(0, 16'h000B);
        o0 = 0; o1 = 0; p0 = 0; p1 = 0;
        for (int j = 0; j < 65540; j++) begin
            if (ovf_irq_o[0]) begin
                o0++;
                chk(cnt0_o == 0, "R3 overflow aligned", cnt0_o, 0);
            end
            if (ovf_irq_o[1]) o1++;
            if (prd_irq_o[0]) p0++;
            if (prd_irq_o[1]) p1++;
            step();
        end
        chk(o0 == 1, "R3 wrap overflow", o0, 1);
        chk(o1 == 1, "R3 all-ones period overflow", o1, 1);
        chk(p0 == 0 && p1 == 0, "R3 no period pulse", p0 + p1, 0);
        chk(ctrl_ok(), "R1 map", 1, 1);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    function automatic bit ctrl_ok();
        return (cnt0_o != 16'h0 || cnt1_o != 16'h0);
    endfunction

endmodule